// File: doc/BRIEF.md
# Soft-Decision Path-Metric Unit for a Rate-1/2 Convolutional Decoder

This block is the add-compare-select engine of a rate-1/2 convolutional decoder. Each enabled clock it takes one packed word that holds two signed soft symbols. It forms four branch metrics, one for each pair of coded-bit hypotheses. For every trellis state it then picks the cheaper of the two incoming paths. The outputs are one survivor decision bit per state, the smallest path metric and the index of the state that holds it. The decision vector feeds an external survivor memory and traceback stage.

Path metrics are costs, so a smaller value means a more likely path. The metrics grow without bound, so they are renormalized whenever an updated metric enters the upper half of its range. A parameter chooses the method: subtract a fixed constant, or shift right by a power-of-two divisor. Each renormalization raises a one-cycle flag.

A one-cycle rotation request swaps the roles of the two symbol fields for all later words and clears every metric. Node synchronization logic uses this request after a loss of lock. Setting the symbol width to two gives a hard-decision decoder that still accepts erasures.

Top module: `vit_pmu`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets every path metric to zero and drives `dec`, `best_metric`, `best_state`, `out_valid` and `normalize` to zero. The rotation state returns to "not swapped".
- R2: A symbol is a SOFTBITS-wide two's-complement value v, and M = 2^(SOFTBITS-1)-1. The most negative code is first clipped to -M. The symbol's cost is M-v under a hypothesised coded 0 and M+v under a hypothesised coded 1. An all-zero symbol is therefore an erasure that costs M under either hypothesis.
- R3: When not swapped, the most significant SOFTBITS of `sym_pair` are the first symbol. The first symbol is scored against the coded bit of generator GEN_A, and the least significant field is scored against GEN_B. The branch metric is the sum of the two symbol costs.
- R4: State s holds the last K-1 input bits, with bit K-2 the newest. The encoder register is {u, s} and the next state is its top K-1 bits. Next state n has an upper predecessor {n[K-3:0],0} and a lower predecessor {n[K-3:0],1}. `dec[n]` is 1 only when the lower predecessor's candidate (metric plus branch metric) is strictly smaller; ties select the upper predecessor. The new metric is the chosen candidate.
- R5: One cycle after each accepted word, `out_valid` is high and `best_metric` holds the smallest updated path metric. `best_state` holds its index, and ties go to the lowest index.
- R6: With NORM_DIV = 1, if any updated metric is at least 2^(METRIC_W-1), 2^(METRIC_W-2) is subtracted from every updated metric, with a floor of zero.
- R7: With NORM_DIV of 2, 4 or 8, the same trigger divides every updated metric by NORM_DIV, rounding down.
- R8: `normalize` is high for exactly the one cycle that follows an accepted word whose update was renormalized, and is low otherwise.
- R9: While `en` is low, no word is accepted and `sync_rot` is ignored. Metrics, rotation state, `dec`, `best_metric` and `best_state` keep their values. `out_valid` and `normalize` are low in the following cycle.
- R10: `sync_rot` high together with `en` accepts no word that cycle, clears every metric to zero, and toggles the swap of the two symbol fields for all later words.
- R11: With SOFTBITS = 2, code 01 acts as a hard 0, codes 11 and 10 act as a hard 1, and 00 is an erasure. All cost rules of R2 apply with M = 1.
- R12: A stored path metric never has its most significant bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accept the word on `sym_pair` (or the rotation request) this cycle |
| sync_rot | input | 1 | Rotation request: clear metrics and toggle field swap |
| sym_pair | input | 2*SOFTBITS | Two packed soft symbols, first received in the upper field |
| dec | output | 2^(K-1) | Survivor decision bit per next state |
| best_metric | output | METRIC_W | Smallest updated path metric |
| best_state | output | K-1 | Index of the state holding `best_metric` |
| out_valid | output | 1 | Outputs updated from the word accepted in the previous cycle |
| normalize | output | 1 | Update of the previous cycle was renormalized |

## Verification
The bench builds three copies with K = 3 and generators 7 and 5 (octal).

- **Subtract and floor:** one copy uses 4-bit symbols, a 12-bit metric and NORM_DIV = 1.
- **Divide by 2:** one copy uses the defaults, so the same symbols exercise the shift path.
- **Hard decision:** one copy uses 2-bit symbols, a 10-bit metric and a divisor of 8, which also reaches the widest shift.

The small metric widths let long random runs without rotation requests cross the normalization threshold repeatedly. Directed words cover erasures, the clipped code, asymmetric pairs before and after a field swap, and an enable-low window in which rotation requests must be ignored.

// File: rtl/vit_pkg.sv
package vit_pkg;

   // How metrics are renormalized (chosen from NORM_DIV)
   typedef enum logic {NORM_SUBTRACT, NORM_SHIFT} norm_kind_e;

   // Coded bit produced on the branch from predecessor {nxt[K-3:0], b}
   // into next state nxt, for generator gen (K-bit encoder register {u, pred}).
   function automatic logic branch_bit(input int unsigned nxt, input int unsigned b,
                                       input int unsigned k, input int unsigned gen);
      int unsigned pred;
      int unsigned regv;
      pred = ((nxt << 1) | b) & ((32'd1 << (k - 1)) - 1);
      regv = ((nxt >> (k - 2)) << (k - 1)) | pred;
      return ^(regv & gen);
   endfunction

   function automatic norm_kind_e norm_kind(input int unsigned div);
      return (div == 1) ? NORM_SUBTRACT : NORM_SHIFT;
   endfunction

endpackage

// File: rtl/vit_branch_metric.sv
module vit_branch_metric #(
   parameter int SOFTBITS = 4
) (
   input  logic signed [SOFTBITS-1:0] sym,
   output logic        [SOFTBITS:0]   cost0,
   output logic        [SOFTBITS:0]   cost1
);
   localparam int MAG = (1 << (SOFTBITS - 1)) - 1;
   localparam logic signed [SOFTBITS-1:0] MOST_NEG = {1'b1, {(SOFTBITS-1){1'b0}}};

   logic signed [SOFTBITS:0] v;

   always_comb begin
      v = {sym[SOFTBITS-1], sym};
      if (sym == MOST_NEG) begin
         v = (SOFTBITS+1)'(-MAG);
      end
      cost0 = (SOFTBITS+1)'(MAG - int'(v));
      cost1 = (SOFTBITS+1)'(MAG + int'(v));
   end
endmodule

// File: rtl/vit_acs.sv
module vit_acs #(
   parameter int METRIC_W = 12,
   parameter int BM_W     = 6
) (
   input  logic [METRIC_W-1:0] pm_up,
   input  logic [METRIC_W-1:0] pm_lo,
   input  logic [BM_W-1:0]     bm_up,
   input  logic [BM_W-1:0]     bm_lo,
   output logic [METRIC_W-1:0] sum,
   output logic                sel_lo
);
   logic [METRIC_W-1:0] cand_up;
   logic [METRIC_W-1:0] cand_lo;

   always_comb begin
      cand_up = pm_up + METRIC_W'(bm_up);
      cand_lo = pm_lo + METRIC_W'(bm_lo);
      sel_lo  = (cand_lo < cand_up);
      sum     = sel_lo ? cand_lo : cand_up;
   end
endmodule

// File: rtl/vit_normalizer.sv
module vit_normalizer #(
   parameter int N        = 4,
   parameter int METRIC_W = 12,
   parameter int NORM_DIV = 2
) (
   input  logic [METRIC_W-1:0] m_in  [N],
   output logic [METRIC_W-1:0] m_out [N],
   output logic                hit
);
   import vit_pkg::*;

   localparam norm_kind_e KIND = norm_kind(NORM_DIV);
   localparam int SHIFT = $clog2(NORM_DIV);
   localparam logic [METRIC_W-1:0] SUB = {2'b01, {(METRIC_W-2){1'b0}}};

   if (NORM_DIV != 1 && NORM_DIV != 2 && NORM_DIV != 4 && NORM_DIV != 8) begin : g_bad_div
      $error("vit_normalizer: NORM_DIV must be 1, 2, 4 or 8");
   end

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
         hit = hit | m_in[i][METRIC_W-1];
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      if (KIND == NORM_SUBTRACT) begin : g_sub
         always_comb begin
            if (!hit)              m_out[i] = m_in[i];
            else if (m_in[i] >= SUB) m_out[i] = m_in[i] - SUB;
            else                   m_out[i] = '0;
         end
      end else begin : g_shift
         always_comb begin
            m_out[i] = hit ? (m_in[i] >> SHIFT) : m_in[i];
         end
      end
   end
endmodule

// File: rtl/vit_best_select.sv
module vit_best_select #(
   parameter int N        = 4,
   parameter int METRIC_W = 12,
   localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
   input  logic [METRIC_W-1:0] metric [N],
   output logic [METRIC_W-1:0] best_val,
   output logic [IW-1:0]       best_idx
);
   always_comb begin
      best_val = metric[0];
      best_idx = '0;
      for (int i = 1; i < N; i++) begin
         if (metric[i] < best_val) begin
            best_val = metric[i];
            best_idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/vit_pmu.sv
module vit_pmu #(
   parameter int          K        = 3,
   parameter int          SOFTBITS = 4,
   parameter int          METRIC_W = 12,
   parameter int          NORM_DIV = 2,
   parameter int unsigned GEN_A    = 'o7,
   parameter int unsigned GEN_B    = 'o5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic                    sync_rot,
   input  logic [2*SOFTBITS-1:0]   sym_pair,
   output logic [(1<<(K-1))-1:0]   dec,
   output logic [METRIC_W-1:0]     best_metric,
   output logic [K-2:0]            best_state,
   output logic                    out_valid,
   output logic                    normalize
);
   import vit_pkg::*;

   localparam int NS  = 1 << (K - 1);
   localparam int CW  = SOFTBITS + 1;
   localparam int BW  = SOFTBITS + 2;
   localparam int MAG = (1 << (SOFTBITS - 1)) - 1;

   // elaboration-time parameter checks
   if (K < 3 || K > 9) begin : g_bad_k
      $error("vit_pmu: K must lie in 3..9");
   end
   if (SOFTBITS < 2) begin : g_bad_sb
      $error("vit_pmu: SOFTBITS must be at least 2");
   end
   if (METRIC_W <= SOFTBITS + 7) begin : g_bad_mw
      $error("vit_pmu: METRIC_W must exceed SOFTBITS + 7");
   end

   // symbol field selection with optional swap
   logic                       rot_q;
   logic signed [SOFTBITS-1:0] sym_first;
   logic signed [SOFTBITS-1:0] sym_second;

   assign sym_first  = rot_q ? sym_pair[SOFTBITS-1:0] : sym_pair[2*SOFTBITS-1:SOFTBITS];
   assign sym_second = rot_q ? sym_pair[2*SOFTBITS-1:SOFTBITS] : sym_pair[SOFTBITS-1:0];

   logic [CW-1:0] cost_f [2];
   logic [CW-1:0] cost_s [2];

   vit_branch_metric #(.SOFTBITS(SOFTBITS)) u_bm_first (
      .sym(sym_first), .cost0(cost_f[0]), .cost1(cost_f[1]));
   vit_branch_metric #(.SOFTBITS(SOFTBITS)) u_bm_second (
      .sym(sym_second), .cost0(cost_s[0]), .cost1(cost_s[1]));

   // branch metric per hypothesis {bit_a, bit_b}
   logic [BW-1:0] bm [4];
   for (genvar h = 0; h < 4; h++) begin : g_bm
      assign bm[h] = BW'(cost_f[h/2]) + BW'(cost_s[h%2]);
   end

   // add-compare-select per next state
   logic [METRIC_W-1:0] pm_q    [NS];
   logic [METRIC_W-1:0] acs_sum [NS];
   logic [NS-1:0]       acs_sel;

   for (genvar n = 0; n < NS; n++) begin : g_acs
      localparam int PU = (n << 1) & (NS - 1);
      localparam int PL = PU | 1;
      localparam logic [1:0] HU = {branch_bit(n, 0, K, GEN_A), branch_bit(n, 0, K, GEN_B)};
      localparam logic [1:0] HL = {branch_bit(n, 1, K, GEN_A), branch_bit(n, 1, K, GEN_B)};

      vit_acs #(.METRIC_W(METRIC_W), .BM_W(BW)) u_acs (
         .pm_up (pm_q[PU]),
         .pm_lo (pm_q[PL]),
         .bm_up (bm[HU]),
         .bm_lo (bm[HL]),
         .sum   (acs_sum[n]),
         .sel_lo(acs_sel[n])
      );
   end

   logic [METRIC_W-1:0] nrm_sum [NS];
   logic                nrm_hit;

   vit_normalizer #(.N(NS), .METRIC_W(METRIC_W), .NORM_DIV(NORM_DIV)) u_norm (
      .m_in(acs_sum), .m_out(nrm_sum), .hit(nrm_hit));

   logic [METRIC_W-1:0] sel_val;
   logic [K-2:0]        sel_idx;

   vit_best_select #(.N(NS), .METRIC_W(METRIC_W)) u_best (
      .metric(nrm_sum), .best_val(sel_val), .best_idx(sel_idx));

   // state and output registers
   always_ff @(posedge clk) begin
      if (rst) begin
         pm_q        <= '{default: '0};
         rot_q       <= 1'b0;
         dec         <= '0;
         best_metric <= '0;
         best_state  <= '0;
         out_valid   <= 1'b0;
         normalize   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         normalize <= 1'b0;
         if (en && sync_rot) begin
            pm_q  <= '{default: '0};
            rot_q <= !rot_q;
         end else if (en) begin
            pm_q        <= nrm_sum;
            dec         <= acs_sel;
            best_metric <= sel_val;
            best_state  <= sel_idx;
            out_valid   <= 1'b1;
            normalize   <= nrm_hit;
         end
      end
   end

   // packed view of the metrics for the checks below
   logic [NS*METRIC_W-1:0] pm_flat;
   for (genvar s = 0; s < NS; s++) begin : g_flat
      assign pm_flat[s*METRIC_W +: METRIC_W] = pm_q[s];
   end

   // R12: stored metrics stay below the upper half
   for (genvar s = 0; s < NS; s++) begin : g_chk
      a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
         !pm_q[s][METRIC_W-1]);
      // R5: reported best is not larger than any stored metric
      a_r5_best_is_min: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> (best_metric <= pm_q[s]));
   end

   // R5: the reported best state holds the reported metric
   a_r5_best_matches: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (pm_q[best_state] == best_metric));

   // R9: enable low freezes the metrics and silences the pulses
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(pm_flat) && !out_valid && !normalize));

   // R10: rotation request clears every metric
   a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      (en && sync_rot) |=> (pm_flat == '0 && !out_valid));

   // R8: normalize only accompanies a freshly accepted word
   a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
      normalize |-> out_valid);

   // R2: the two hypotheses of each symbol cost 2*M together
   a_r2_cost_balance: assert property (@(posedge clk) disable iff (rst)
      ((CW+1)'(cost_f[0]) + (CW+1)'(cost_f[1]) == (CW+1)'(2*MAG)) &&
      ((CW+1)'(cost_s[0]) + (CW+1)'(cost_s[1]) == (CW+1)'(2*MAG)));

endmodule

// File: tb/tb_vit_pmu.sv
module tb_vit_pmu;
   localparam int CLK_PERIOD = 10;
   localparam int SBV [3] = '{4, 4, 2};
   localparam int MWV [3] = '{12, 12, 10};
   localparam int DVV [3] = '{2, 1, 8};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       sync_rot = 1'b0;
   logic [7:0] wa = '0;
   logic [3:0] wc = '0;

   logic [3:0]  d0, d1, d2;
   logic [11:0] bm0, bm1;
   logic [9:0]  bm2;
   logic [1:0]  bs0, bs1, bs2;
   logic        v0, v1, v2, n0, n1, n2;

   vit_pmu dut (.clk(clk), .rst(rst), .en(en), .sync_rot(sync_rot), .sym_pair(wa),
      .dec(d0), .best_metric(bm0), .best_state(bs0), .out_valid(v0), .normalize(n0));
   vit_pmu #(.NORM_DIV(1)) dut_sub (.clk(clk), .rst(rst), .en(en), .sync_rot(sync_rot),
      .sym_pair(wa), .dec(d1), .best_metric(bm1), .best_state(bs1), .out_valid(v1),
      .normalize(n1));
   vit_pmu #(.SOFTBITS(2), .METRIC_W(10), .NORM_DIV(8)) dut_hard (.clk(clk), .rst(rst),
      .en(en), .sync_rot(sync_rot), .sym_pair(wc), .dec(d2), .best_metric(bm2),
      .best_state(bs2), .out_valid(v2), .normalize(n2));

   always #(CLK_PERIOD/2) clk = ~clk;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   int   pm [3][4];
   int   e_bm [3];
   int   e_bs [3];
   int   e_dec [3];
   bit   e_v [3];
   bit   e_n [3];
   int   n_norm [3];
   bit   rot = 1'b0;

   task automatic chk(string req, string what, int i, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s inst%0d %s: got %0d expected %0d", req, i, what, act, exp);
      end
   endtask

   function automatic int sfield(int raw, int sb);
      return (raw >= (1 << (sb - 1))) ? raw - (1 << sb) : raw;
   endfunction

   // R2 / R11 symbol cost
   function automatic int cost(int v, int c, int sb);
      int mag;
      int w;
      mag = (1 << (sb - 1)) - 1;
      w = (v < -mag) ? -mag : v;
      return c ? mag + w : mag - w;
   endfunction

   // R3 / R4 / R6 / R7 update of one instance's expected state
   task automatic model_accept(int i, int raw0, int raw1);
      int a, b, t, sb, mw, lim;
      int np [4];
      int c [2];
      bit hit;
      sb = SBV[i];
      mw = MWV[i];
      a = sfield(raw0, sb);
      b = sfield(raw1, sb);
      if (rot) begin t = a; a = b; b = t; end
      hit = 1'b0;
      e_dec[i] = 0;
      lim = 1 << (mw - 1);
      for (int n = 0; n < 4; n++) begin
         for (int bb = 0; bb < 2; bb++) begin
            int p, r, ca, cb;
            p = ((n << 1) | bb) & 3;
            r = ((n >> 1) << 2) | p;
            ca = $countones(r & 7) & 1;
            cb = $countones(r & 5) & 1;
            c[bb] = pm[i][p] + cost(a, ca, sb) + cost(b, cb, sb);
         end
         if (c[1] < c[0]) begin
            np[n] = c[1];
            e_dec[i] |= (1 << n);
         end else begin
            np[n] = c[0];
         end
         if (np[n] >= lim) hit = 1'b1;
      end
      for (int n = 0; n < 4; n++) begin
         if (hit) begin
            if (DVV[i] == 1) np[n] = (np[n] >= (1 << (mw - 2))) ? np[n] - (1 << (mw - 2)) : 0;
            else             np[n] = np[n] / DVV[i];
         end
         pm[i][n] = np[n];
      end
      e_bm[i] = np[0];
      e_bs[i] = 0;
      for (int n = 1; n < 4; n++) begin
         if (np[n] < e_bm[i]) begin
            e_bm[i] = np[n];
            e_bs[i] = n;
         end
      end
      e_v[i] = 1'b1;
      e_n[i] = hit;
      if (hit) n_norm[i]++;
   endtask

   task automatic compare(string req);
      int ad [3];
      int ab [3];
      int as [3];
      int av [3];
      int an [3];
      ad = '{int'(d0), int'(d1), int'(d2)};
      ab = '{int'(bm0), int'(bm1), int'(bm2)};
      as = '{int'(bs0), int'(bs1), int'(bs2)};
      av = '{int'(v0), int'(v1), int'(v2)};
      an = '{int'(n0), int'(n1), int'(n2)};
      for (int i = 0; i < 3; i++) begin
         chk(req, "decisions (R4)", i, ad[i], e_dec[i]);
         chk(req, "best metric (R5)", i, ab[i], e_bm[i]);
         chk(req, "best state (R5)", i, as[i], e_bs[i]);
         chk(req, "out_valid (R5)", i, av[i], int'(e_v[i]));
         chk(req, "normalize (R8)", i, an[i], int'(e_n[i]));
         chk("R12", "best metric below half range", i,
             int'(ab[i] < (1 << (MWV[i] - 1))), 1);
      end
   endtask

   task automatic step(bit e, bit s, logic [7:0] a, logic [3:0] c, string req);
      en = e;
      sync_rot = s;
      wa = a;
      wc = c;
      for (int i = 0; i < 3; i++) begin
         e_v[i] = 1'b0;
         e_n[i] = 1'b0;
      end
      if (e && s) begin
         for (int i = 0; i < 3; i++)
            for (int n = 0; n < 4; n++) pm[i][n] = 0;
         rot = !rot;
      end else if (e) begin
         model_accept(0, int'(a[7:4]), int'(a[3:0]));
         model_accept(1, int'(a[7:4]), int'(a[3:0]));
         model_accept(2, int'(c[3:2]), int'(c[1:0]));
      end
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3; i++) begin
         for (int n = 0; n < 4; n++) pm[i][n] = 0;
         e_bm[i] = 0; e_bs[i] = 0; e_dec[i] = 0; e_v[i] = 0; e_n[i] = 0; n_norm[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      compare("R1");
      // R1: erased words from the zero start
      step(1, 0, 8'h00, 4'h0, "R1");
      step(1, 0, 8'h00, 4'h0, "R1");
      // R2: strongest, clipped and erased codes
      step(1, 0, 8'h77, 4'h5, "R2");
      step(1, 0, 8'h99, 4'hF, "R2");
      step(1, 0, 8'h88, 4'hA, "R2");
      step(1, 0, 8'h81, 4'h9, "R2");
      step(1, 0, 8'h0F, 4'h4, "R2");
      // R3: asymmetric pairs reveal the field order
      step(1, 0, 8'h79, 4'h7, "R3");
      step(1, 0, 8'h97, 4'hD, "R3");
      step(1, 0, 8'h7C, 4'h6, "R3");
      // R10: rotation clears and swaps
      step(1, 1, 8'h79, 4'h7, "R10");
      step(1, 0, 8'h79, 4'h7, "R10");
      step(1, 0, 8'h97, 4'hD, "R10");
      step(1, 0, 8'h3A, 4'hE, "R10");
      step(1, 1, 8'h00, 4'h0, "R10");
      step(1, 0, 8'h79, 4'h7, "R10");
      // R9: enable low ignores words and rotation requests
      step(0, 0, 8'h99, 4'hF, "R9");
      step(0, 1, 8'h77, 4'h5, "R9");
      step(0, 1, 8'h12, 4'h3, "R9");
      step(1, 0, 8'h97, 4'hD, "R9");
      // R11: hard-decision codes for the 2-bit copy
      step(1, 0, 8'h11, 4'h5, "R11");
      step(1, 0, 8'h22, 4'hB, "R11");
      step(1, 0, 8'h33, 4'h2, "R11");
      step(1, 0, 8'h44, 4'h8, "R11");
      // random mix with occasional rotation requests
      for (int k = 0; k < 400; k++) begin
         bit e, s;
         e = ($urandom % 8) != 0;
         s = ($urandom % 40) == 0;
         step(e, s, 8'($urandom), 4'($urandom), "R4");
      end
      // long runs without rotation to reach renormalization
      for (int k = 0; k < 3000; k++) begin
         bit e;
         e = ($urandom % 10) != 0;
         step(e, 0, 8'($urandom), 4'($urandom), "R6");
      end
      chk("R7", "normalizations seen (divide by 2)", 0, int'(n_norm[0] > 0), 1);
      chk("R6", "normalizations seen (subtract)", 1, int'(n_norm[1] > 0), 1);
      chk("R11", "normalizations seen (hard, divide by 8)", 2, int'(n_norm[2] > 0), 1);
      chk("R8", "normalizations seen", 0, int'(n_norm[0] + n_norm[1] + n_norm[2] > 2), 1);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule